// File: doc/BRIEF.md
# Coin-Accumulating Vending Controller

This block is the control state machine of a gum dispenser. A coin sensor sends it one-cycle pulses, one line for a 5-cent coin and one for a 10-cent coin. The controller keeps a running credit in 5-cent units. When the credit reaches 15 cents or more it raises the release output, which drives the package mechanism. It never returns change: a 10-cent coin that takes the credit from 10 to 20 cents still buys one package, and the credit stays at its top level.

The top level is held until a synchronous reset returns it to zero credit. The credit at which a package is released is a parameter, counted in 5-cent units, with a default of 3.

A second parameter picks when the release output is seen. In registered-state timing, the output follows the clock edge at which the credit reaches the release level. In input-decoded timing, the output also rises in the same cycle as the coin pulse that completes the payment, before that edge.

Top module: `vend_ctrl`

## Requirements
- R1: A high `rst` at a rising clock edge sets the credit to zero and leaves `vend_open` low after that edge, whatever the coin inputs are. In input-decoded mode, `vend_open` is also held low in every cycle in which `rst` is high.
- R2: A cycle with only `nickel_i` high adds one credit unit (5 cents) at the next edge.
- R3: A cycle with only `dime_i` high adds two credit units (10 cents) at the next edge.
- R4: The credit saturates at the release level (`VEND_UNITS`, default 3 = 15 cents). A 10-cent coin at 10 cents reaches that level and does not wrap to a lower credit.
- R5: Once at the release level, the credit and a high `vend_open` hold through any coin inputs until reset.
- R6: A cycle with `nickel_i` and `dime_i` both high leaves the credit unchanged and does not newly raise `vend_open`.
- R7: With `OUT_MEALY` = 0, `vend_open` is a register. It is high exactly in the cycles after the edge that brought the credit to the release level.
- R8: With `OUT_MEALY` = 1, `vend_open` is high whenever the credit is at the release level. It is also high, combinationally, in a cycle where a single coin completes the payment: 5 cents at 10 cents, or 10 cents at 5 or 10 cents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| nickel_i | input | 1 | 5-cent coin pulse, one cycle per coin |
| dime_i | input | 1 | 10-cent coin pulse, one cycle per coin |
| vend_open | output | 1 | Release command to the package mechanism |

## Verification
The bench aims at the payment paths that overshoot or just reach the release level:
- Dime after dime: a design that wraps instead of saturating would fall back to a low credit and drop the release.
- Nickel then dime: a design that forgets the credit from the nickel would wait for another coin.
- Both coin lines high in one cycle: a design that adds either coin, or both, would vend early or change its credit.

Reset is applied while a coin pulse is present and while the machine sits at the full level. A reset that loses to the coin, or that leaves residue, shows up as a release one coin too soon afterwards. Both output timings run on the same stimulus, so a Mealy output that lags, or a Moore output that leads, is caught in the cycle where the two must differ.

// File: rtl/vend_pkg.sv
`timescale 1ns/1ps
package vend_pkg;
  // credit value of each coin, in 5-cent units
  localparam int NICKEL_UNITS = 1;
  localparam int DIME_UNITS   = 2;

  typedef struct packed {
    logic dime;
    logic nick;
  } coin_t;

  // a cycle with no coin or with both lines high carries no credit
  function automatic int coin_units(coin_t c);
    if (c.nick ^ c.dime) return c.dime ? DIME_UNITS : NICKEL_UNITS;
    return 0;
  endfunction
endpackage

// File: rtl/vend_credit_step.sv
`timescale 1ns/1ps
module vend_credit_step
  import vend_pkg::*;
#(
  parameter int FULL = 3,
  parameter int W    = 2
) (
  input  logic [W-1:0] credit_q,
  input  coin_t        coin,
  output logic [W-1:0] credit_nxt,
  output logic         completes
);
  int units;
  int sum;

  always_comb begin
    units = coin_units(coin);
    sum   = int'(credit_q) + units;
    if (int'(credit_q) >= FULL) begin
      credit_nxt = credit_q;
      completes  = 1'b0;
    end else if (sum >= FULL) begin
      credit_nxt = W'(FULL);
      completes  = 1'b1;
    end else begin
      credit_nxt = W'(sum);
      completes  = 1'b0;
    end
  end
endmodule

// File: rtl/vend_open_stage.sv
`timescale 1ns/1ps
module vend_open_stage #(
  parameter int FULL  = 3,
  parameter int W     = 2,
  parameter bit MEALY = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] credit_q,
  input  logic [W-1:0] credit_nxt,
  input  logic         completes,
  output logic         vend_open
);
  logic moore_q;
  logic mealy_c;

  // registered form: follows the credit that is about to be stored
  always_ff @(posedge clk) begin
    if (rst) moore_q <= 1'b0;
    else     moore_q <= (int'(credit_nxt) == FULL);
  end

  // input-decoded form: full credit, or a coin that completes the payment now
  always_comb mealy_c = !rst && ((int'(credit_q) == FULL) || completes);

  assign vend_open = MEALY ? mealy_c : moore_q;
endmodule

// File: rtl/vend_ctrl.sv
`timescale 1ns/1ps
module vend_ctrl
  import vend_pkg::*;
#(
  parameter bit OUT_MEALY  = 1'b0,
  parameter int VEND_UNITS = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic nickel_i,
  input  logic dime_i,
  output logic vend_open
);
  localparam int W = $clog2(VEND_UNITS + 1);

  logic [W-1:0] credit_q;
  logic [W-1:0] credit_nxt;
  logic         completes;
  coin_t        coin;

  assign coin = '{dime: dime_i, nick: nickel_i};

  vend_credit_step #(.FULL(VEND_UNITS), .W(W)) u_step (
    .credit_q  (credit_q),
    .coin      (coin),
    .credit_nxt(credit_nxt),
    .completes (completes)
  );

  always_ff @(posedge clk) begin
    if (rst) credit_q <= '0;
    else     credit_q <= credit_nxt;
  end

  vend_open_stage #(.FULL(VEND_UNITS), .W(W), .MEALY(OUT_MEALY)) u_out (
    .clk       (clk),
    .rst       (rst),
    .credit_q  (credit_q),
    .credit_nxt(credit_nxt),
    .completes (completes),
    .vend_open (vend_open)
  );
endmodule

// File: rtl/vend_ctrl_chk.sv
`timescale 1ns/1ps
module vend_ctrl_chk #(
  parameter int FULL  = 3,
  parameter int W     = 2,
  parameter bit MEALY = 1'b0
) (
  input logic         clk,
  input logic         rst,
  input logic         nickel_i,
  input logic         dime_i,
  input logic [W-1:0] credit_q,
  input logic         vend_open
);
  logic seen_edge = 1'b0;
  always_ff @(posedge clk) seen_edge <= 1'b1;

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (credit_q == '0) && !vend_open);

  a_r2_nickel_adds_one: assert property (@(posedge clk) disable iff (rst || !seen_edge)
    (nickel_i && !dime_i && int'(credit_q) < FULL)
    |=> int'(credit_q) == int'($past(credit_q)) + 1);

  a_r3_dime_adds_two: assert property (@(posedge clk) disable iff (rst || !seen_edge)
    (dime_i && !nickel_i && int'(credit_q) < FULL)
    |=> int'(credit_q) == ((int'($past(credit_q)) + 2 > FULL) ? FULL : int'($past(credit_q)) + 2));

  a_r4_never_above_full: assert property (@(posedge clk) disable iff (rst || !seen_edge)
    int'(credit_q) <= FULL);

  a_r5_full_holds: assert property (@(posedge clk) disable iff (rst || !seen_edge)
    (int'(credit_q) == FULL) |=> (int'(credit_q) == FULL) && vend_open);

  a_r6_both_coins_hold: assert property (@(posedge clk) disable iff (rst || !seen_edge)
    (nickel_i && dime_i) |=> $stable(credit_q));

  if (MEALY) begin : g_mly
    a_r8_early_release: assert property (@(posedge clk) disable iff (rst || !seen_edge)
      (int'(credit_q) == FULL - 1 && nickel_i && !dime_i) |-> vend_open);
  end else begin : g_moore
    a_r7_open_tracks_full: assert property (@(posedge clk) disable iff (rst || !seen_edge)
      vend_open == (int'(credit_q) == FULL));
  end
endmodule

bind vend_ctrl vend_ctrl_chk #(.FULL(VEND_UNITS), .W(W), .MEALY(OUT_MEALY)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .nickel_i (nickel_i),
  .dime_i   (dime_i),
  .credit_q (credit_q),
  .vend_open(vend_open)
);

// File: tb/tb_vend_ctrl.sv
`timescale 1ns/1ps
module tb_vend_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic nickel_i = 1'b0;
  logic dime_i = 1'b0;
  logic open_moore;
  logic open_mealy;
  int   n_run = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;   // 200 MHz

  vend_ctrl #(.OUT_MEALY(1'b0)) dut (
    .clk(clk), .rst(rst), .nickel_i(nickel_i), .dime_i(dime_i), .vend_open(open_moore));

  vend_ctrl #(.OUT_MEALY(1'b1)) dut_mly (
    .clk(clk), .rst(rst), .nickel_i(nickel_i), .dime_i(dime_i), .vend_open(open_mealy));

  // {rst, dime, nickel, mealy open in this cycle, moore open after the edge}
  localparam int NV = 32;
  localparam logic [4:0] VEC [NV] = '{
    5'b10000,  //  0 reset (R1)
    5'b00100,  //  1 N -> 5c (R2)
    5'b00100,  //  2 N -> 10c (R2)
    5'b00111,  //  3 N -> 15c, Mealy early (R8), Moore after (R7)
    5'b00011,  //  4 idle at full (R5)
    5'b00111,  //  5 N at full holds (R5)
    5'b10100,  //  6 reset wins over coin (R1)
    5'b01000,  //  7 D -> 10c (R3)
    5'b00111,  //  8 N -> 15c (R2)
    5'b10000,  //  9 reset
    5'b00100,  // 10 N -> 5c
    5'b01011,  // 11 D at 5c completes (R3, R8)
    5'b10000,  // 12 reset
    5'b01000,  // 13 D -> 10c
    5'b01011,  // 14 D at 10c saturates, one release (R4)
    5'b00011,  // 15 idle stays full (R4)
    5'b01011,  // 16 D at full holds (R5)
    5'b10000,  // 17 reset
    5'b00100,  // 18 N -> 5c
    5'b01100,  // 19 both lines: hold (R6)
    5'b00000,  // 20 still 5c (R6)
    5'b00100,  // 21 N -> 10c
    5'b01100,  // 22 both at 10c: no release (R6)
    5'b00000,  // 23 still 10c (R6)
    5'b01011,  // 24 D at 10c -> full
    5'b01111,  // 25 both at full stays high (R5, R6)
    5'b10000,  // 26 reset from full (R1)
    5'b00000,  // 27 idle at zero
    5'b00100,  // 28 N -> 5c, proves reset left zero (R1)
    5'b00100,  // 29 N -> 10c
    5'b00000,  // 30 idle, no release
    5'b00111   // 31 N -> 15c
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset moore", open_moore, 1'b0);
    check("R1 reset mealy", open_mealy, 1'b0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      if (i > 0) check("R7 moore after edge", open_moore, VEC[i-1][0]);
      rst      = VEC[i][4];
      dime_i   = VEC[i][3];
      nickel_i = VEC[i][2];
      #1;
      check("R8 mealy in cycle", open_mealy, VEC[i][1]);
    end
    @(negedge clk);
    check("R7 moore after edge", open_moore, VEC[NV-1][0]);

    // full level holds through any coin pattern (R5)
    for (int k = 0; k < 12; k++) begin
      nickel_i = (k % 3) != 1;
      dime_i   = (k % 3) != 0;
      rst      = 1'b0;
      #1;
      check("R5 hold mealy", open_mealy, 1'b1);
      @(negedge clk);
      check("R5 hold moore", open_moore, 1'b1);
    end

    // reset while a dime arrives at full: Mealy low during, both low after (R1)
    rst = 1'b1; dime_i = 1'b1; nickel_i = 1'b0;
    #1;
    check("R1 mealy low in reset", open_mealy, 1'b0);
    @(negedge clk);
    rst = 1'b0; dime_i = 1'b0;
    check("R1 moore low after reset", open_moore, 1'b0);
    #1;
    check("R1 mealy low after reset", open_mealy, 1'b0);
    @(negedge clk);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule